// File: doc/BRIEF.md
# Descriptor DMA Channel Register Bank

This block is the register window of one descriptor-driven DMA channel. A host writes and reads 32-bit words in a 256-byte window. The block keeps the control flags, the pointer words and the select words that the channel sequencer uses. It turns the writable control bits into level and pulse strobes for the sequencer. The sequencer returns its active, dead and branch flags and an 8-bit device status, and the block captures them.

The control word takes a combined write. The upper half of the written value is a per-bit enable and the lower half holds the new bit values. Software can therefore set or clear a single control bit without first reading the word. Every word crosses the bus in little-endian byte order, so the block swaps the bytes on both writes and reads.

The window is selected by the address bits above bit 7, which must equal the channel index parameter. The data path that moves the data is not part of this block.

Top module: `dma_chan_regs`

## Requirements
- R1: On a write to word 0, the value after the byte swap gives an enable mask in bits 31:16 and new values in bits 15:0. Run (bit 15) and pause (bit 14) take the new value only where the mask bit is 1. Where the mask bit is 0 they keep their value. Writing the bit in both halves sets it, and writing the mask bit alone clears it.
- R2: The branch flag (bit 8), active (bit 10), dead (bit 11), reserved bit 9 and status bits 7:0 ignore control writes, including writes whose mask selects them.
- R3: A control write that sets wake (bit 12) or flush (bit 13) in both halves raises `wake_pulse` or `flush_pulse` for exactly the one cycle after the write edge. Both bits always read back as 0.
- R4: A control write that clears run makes the active flag read 0 from the next cycle, even while `seq_active` stays 1. Active reads as `seq_active` AND run.
- R5: Writes to the command pointer words (word 2 high, word 3 low) are dropped while the active flag is 1. They are accepted while it is 0.
- R6: Every word is byte-swapped on the bus: writing bus value W to a storage word makes it read back W. The matching output port carries the byte-reversed value. The words are: 2/3 command pointer, 4 interrupt select, 5 branch select, 6 wait select, 7 transfer mode, 8/9 data pointer, 11/12 branch pointer, with the high half first in each pair.
- R7: Words 0 and 1 both read the flag word {run, pause, 0, 0, dead, active, 0, branch, status[7:0]} in bits 15:0, with bits 31:16 zero. The sequencer inputs appear one cycle after they are applied.
- R8: Word 10 and words 13 and above read 0, and writes to them change nothing.
- R9: An access whose address bits above bit 7 differ from `CHAN_ID` reads 0 and changes no state.
- R10: After reset every word reads 0 and all strobes and pointer outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Byte address; bits 7:2 pick the word, upper bits the channel |
| wr_data | input | 32 | Write data, little-endian on the bus |
| rd_data | output | 32 | Read data for `addr`, little-endian, combinational |
| seq_active | input | 1 | Sequencer active flag |
| seq_dead | input | 1 | Sequencer dead flag |
| seq_branch | input | 1 | Sequencer branch condition flag |
| seq_status | input | 8 | Device status bits |
| run_o | output | 1 | Run level to the sequencer |
| pause_o | output | 1 | Pause level to the sequencer |
| flush_pulse | output | 1 | One-cycle flush request |
| wake_pulse | output | 1 | One-cycle wake request |
| cmd_ptr | output | 64 | Command pointer {high, low} |
| data_ptr | output | 64 | Data pointer {high, low} |
| branch_ptr | output | 64 | Branch pointer {high, low} |
| int_sel | output | 32 | Interrupt select word |
| br_sel | output | 32 | Branch select word |
| wait_sel | output | 32 | Wait select word |
| xfer_mode | output | 32 | Transfer mode word |

## Verification
A write takes effect at the clock edge that samples it. Stored words, run and pause, and the pulses are all visible on the ports in the same cycle, after that edge. The pulses fall again one edge later. Sequencer inputs pass through one register, so the flag word shows them one edge after they are applied. The read port is combinational from the stored state. The bench therefore drives inputs on the falling edge and compares each result at the falling edge that follows the edge where the result is due. It also checks each pulse at the next falling edge to confirm that it has dropped.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int WORD_W    = 32;
    localparam int BANK_LEN  = 16;

    localparam int OFF_CTRL   = 0;
    localparam int OFF_STAT   = 1;
    localparam int OFF_CMD_HI = 2;
    localparam int OFF_CMD_LO = 3;
    localparam int OFF_INTSEL = 4;
    localparam int OFF_BRSEL  = 5;
    localparam int OFF_WAIT   = 6;
    localparam int OFF_XFER   = 7;
    localparam int OFF_DAT_HI = 8;
    localparam int OFF_DAT_LO = 9;
    localparam int OFF_RSVD   = 10;
    localparam int OFF_BRP_HI = 11;
    localparam int OFF_BRP_LO = 12;

    localparam int BIT_BRANCH = 8;
    localparam int BIT_ACTIVE = 10;
    localparam int BIT_DEAD   = 11;
    localparam int BIT_WAKE   = 12;
    localparam int BIT_FLUSH  = 13;
    localparam int BIT_PAUSE  = 14;
    localparam int BIT_RUN    = 15;

    typedef struct packed {
        logic       run;
        logic       pause;
        logic       flush_p;
        logic       wake_p;
        logic       active;
        logic       dead;
        logic       branch;
        logic [7:0] status;
    } ctrl_state_t;

    function automatic logic [WORD_W-1:0] bswap32(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic is_storage(input int off);
        return (off >= OFF_CMD_HI && off <= OFF_DAT_LO) ||
               off == OFF_BRP_HI || off == OFF_BRP_LO;
    endfunction

    function automatic logic is_cmd_word(input int off);
        return off == OFF_CMD_HI || off == OFF_CMD_LO;
    endfunction

endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode #(
    parameter int ADDR_W   = 12,
    parameter int WIN_BITS = 8,
    parameter int CHAN_ID  = 3,
    localparam int IDX_W   = WIN_BITS - 2,
    localparam int CH_W    = ADDR_W - WIN_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  word_idx
);
    always_comb begin
        hit      = (addr[ADDR_W-1:WIN_BITS] == CH_W'(CHAN_ID));
        word_idx = addr[WIN_BITS-1:2];
    end
endmodule

// File: rtl/dma_ctrl_flags.sv
module dma_ctrl_flags
    import dma_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [31:0] wdata,
    input  logic        seq_active,
    input  logic        seq_dead,
    input  logic        seq_branch,
    input  logic [7:0]  seq_status,
    output logic        run_o,
    output logic        pause_o,
    output logic        flush_o,
    output logic        wake_o,
    output logic        active_o,
    output logic [15:0] flags_o
);
    ctrl_state_t st_d, st_q;
    logic [15:0] msk, val;

    always_comb begin
        msk = wdata[31:16];
        val = wdata[15:0];
        st_d         = st_q;
        st_d.flush_p = 1'b0;
        st_d.wake_p  = 1'b0;
        if (ctrl_wr) begin
            if (msk[BIT_RUN])   st_d.run   = val[BIT_RUN];
            if (msk[BIT_PAUSE]) st_d.pause = val[BIT_PAUSE];
            st_d.flush_p = msk[BIT_FLUSH] & val[BIT_FLUSH];
            st_d.wake_p  = msk[BIT_WAKE]  & val[BIT_WAKE];
        end
        st_d.active = seq_active & st_d.run;
        st_d.dead   = seq_dead;
        st_d.branch = seq_branch;
        st_d.status = seq_status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        flags_o             = '0;
        flags_o[7:0]        = st_q.status;
        flags_o[BIT_BRANCH] = st_q.branch;
        flags_o[BIT_ACTIVE] = st_q.active;
        flags_o[BIT_DEAD]   = st_q.dead;
        flags_o[BIT_PAUSE]  = st_q.pause;
        flags_o[BIT_RUN]    = st_q.run;
        run_o    = st_q.run;
        pause_o  = st_q.pause;
        flush_o  = st_q.flush_p;
        wake_o   = st_q.wake_p;
        active_o = st_q.active;
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wdata[16+BIT_PAUSE] && !wdata[16+BIT_RUN]) |=> ($stable(pause_o) && $stable(run_o))); // R1
    AST_RUN_CLEAR_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[16+BIT_RUN] && !wdata[BIT_RUN]) |=> !active_o); // R4
    AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o || wake_o) |-> $past(ctrl_wr)); // R3
    AST_SELF_CLEAR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[BIT_WAKE] == 1'b0) && (flags_o[BIT_FLUSH] == 1'b0)); // R3
endmodule

// File: rtl/dma_ptr_bank.sv
module dma_ptr_bank
    import dma_regs_pkg::*;
#(
    parameter int N_WORDS = BANK_LEN,
    localparam int IW     = $clog2(N_WORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IW-1:0]             wr_idx,
    input  logic [31:0]               wdata,
    input  logic                      lock_cmd,
    output logic [N_WORDS-1:0][31:0]  words_o
);
    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        if (is_storage(i)) begin : g_store
            logic [31:0] word_d, word_q;
            logic        take;

            always_comb begin
                take   = wr_en && (wr_idx == IW'(i)) && !(is_cmd_word(i) && lock_cmd);
                word_d = take ? wdata : word_q;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) word_q <= '0;
                else        word_q <= word_d;
            end

            assign words_o[i] = word_q;

            if (is_cmd_word(i)) begin : g_lock_chk
                AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
                    lock_cmd |=> $stable(word_q)); // R5
            end
        end else begin : g_none
            assign words_o[i] = '0;
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int WIN_BITS = 8,
    parameter int CHAN_ID  = 3,
    localparam int IDX_W   = WIN_BITS - 2,
    localparam int BIW     = $clog2(BANK_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              seq_active,
    input  logic              seq_dead,
    input  logic              seq_branch,
    input  logic [7:0]        seq_status,
    output logic              run_o,
    output logic              pause_o,
    output logic              flush_pulse,
    output logic              wake_pulse,
    output logic [63:0]       cmd_ptr,
    output logic [63:0]       data_ptr,
    output logic [63:0]       branch_ptr,
    output logic [31:0]       int_sel,
    output logic [31:0]       br_sel,
    output logic [31:0]       wait_sel,
    output logic [31:0]       xfer_mode
);
    logic                       hit;
    logic [IDX_W-1:0]           widx;
    logic [31:0]                wint;
    logic                       in_bank, ctrl_wr, bank_wr, active;
    logic [15:0]                flags;
    logic [BANK_LEN-1:0][31:0]  words;
    logic [31:0]                rd_int;

    dma_addr_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .CHAN_ID(CHAN_ID)) i_dec (
        .addr(addr), .hit(hit), .word_idx(widx)
    );

    always_comb begin
        wint    = bswap32(wr_data);
        in_bank = (widx < IDX_W'(BANK_LEN));
        ctrl_wr = wr_en && hit && (widx == IDX_W'(OFF_CTRL));
        bank_wr = wr_en && hit && in_bank;
    end

    dma_ctrl_flags i_flags (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(wint),
        .seq_active(seq_active), .seq_dead(seq_dead), .seq_branch(seq_branch),
        .seq_status(seq_status), .run_o(run_o), .pause_o(pause_o),
        .flush_o(flush_pulse), .wake_o(wake_pulse), .active_o(active), .flags_o(flags)
    );

    dma_ptr_bank #(.N_WORDS(BANK_LEN)) i_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(bank_wr), .wr_idx(widx[BIW-1:0]),
        .wdata(wint), .lock_cmd(active), .words_o(words)
    );

    always_comb begin
        rd_int = '0;
        if (hit) begin
            if (widx == IDX_W'(OFF_CTRL) || widx == IDX_W'(OFF_STAT))
                rd_int = {16'h0, flags};
            else if (in_bank)
                rd_int = words[widx[BIW-1:0]];
        end
        rd_data    = bswap32(rd_int);
        cmd_ptr    = {words[OFF_CMD_HI], words[OFF_CMD_LO]};
        data_ptr   = {words[OFF_DAT_HI], words[OFF_DAT_LO]};
        branch_ptr = {words[OFF_BRP_HI], words[OFF_BRP_LO]};
        int_sel    = words[OFF_INTSEL];
        br_sel     = words[OFF_BRSEL];
        wait_sel   = words[OFF_WAIT];
        xfer_mode  = words[OFF_XFER];
    end

    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (rd_data == '0)); // R9
    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (widx == IDX_W'(OFF_RSVD) || widx > IDX_W'(OFF_BRP_LO))) |-> (rd_data == '0)); // R8
endmodule

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
    localparam int ADDR_W = 12;
    localparam int CHAN   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        seq_active = 1'b0, seq_dead = 1'b0, seq_branch = 1'b0;
    logic [7:0]  seq_status = '0;
    logic        run_o, pause_o, flush_pulse, wake_pulse;
    logic [63:0] cmd_ptr, data_ptr, branch_ptr;
    logic [31:0] int_sel, br_sel, wait_sel, xfer_mode;

    int n_cmp = 0;
    int n_bad = 0;
    logic        m_run = 0, m_pause = 0;
    logic [31:0] m_word [16];

    always #2.5 clk = ~clk;

    dma_chan_regs #(.ADDR_W(ADDR_W), .WIN_BITS(8), .CHAN_ID(CHAN)) i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .seq_active(seq_active), .seq_dead(seq_dead),
        .seq_branch(seq_branch), .seq_status(seq_status), .run_o(run_o),
        .pause_o(pause_o), .flush_pulse(flush_pulse), .wake_pulse(wake_pulse),
        .cmd_ptr(cmd_ptr), .data_ptr(data_ptr), .branch_ptr(branch_ptr),
        .int_sel(int_sel), .br_sel(br_sel), .wait_sel(wait_sel), .xfer_mode(xfer_mode)
    );

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [11:0] a_of(input int ch, input int off);
        return {4'(ch), 8'(off * 4)};
    endfunction

    function automatic logic [31:0] exp_flags(input logic act, input logic dead,
                                              input logic br, input logic [7:0] st);
        return {16'h0, m_run, m_pause, 2'b00, dead, act, 1'b0, br, st};
    endfunction

    function automatic logic stored(input int off);
        return (off >= 2 && off <= 9) || off == 11 || off == 12;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // write an internal-order value; bus carries the swapped bytes
    task automatic wr(input int ch, input int off, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a_of(ch, off); wr_data = swap32(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ctrl_wr(input logic [15:0] m, input logic [15:0] v);
        wr(CHAN, 0, {m, v});
        if (m[15]) m_run = v[15];
        if (m[14]) m_pause = v[14];
    endtask

    task automatic rd_chk(input string req, input int ch, input int off, input logic [31:0] exp);
        wr_en = 1'b0; addr = a_of(ch, off); #1;
        chk(req, swap32(rd_data), exp);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) m_word[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        for (int o = 0; o < 16; o++) rd_chk("R10", CHAN, o, 32'h0);
        chk("R10", {run_o, pause_o, flush_pulse, wake_pulse}, 0);
        chk("R10", cmd_ptr | data_ptr | branch_ptr, 0);

        // R7 flag positions with run set
        ctrl_wr(16'h8000, 16'h8000);
        seq_active = 1; seq_dead = 1; seq_branch = 1; seq_status = 8'hA5;
        @(negedge clk);
        rd_chk("R7", CHAN, 0, exp_flags(1, 1, 1, 8'hA5));
        rd_chk("R7", CHAN, 1, exp_flags(1, 1, 1, 8'hA5));
        chk("R7", run_o, 1);

        // R2 read-only bits ignore masked writes
        ctrl_wr(16'h0FFF, 16'h0000);
        rd_chk("R2", CHAN, 0, exp_flags(1, 1, 1, 8'hA5));
        ctrl_wr(16'h0FFF, 16'h0FFF);
        rd_chk("R2", CHAN, 0, exp_flags(1, 1, 1, 8'hA5));

        // R5 command pointer locked while active
        wr(CHAN, 3, 32'hDEAD_BEEF);
        rd_chk("R5", CHAN, 3, 32'h0);
        chk("R5", cmd_ptr, 64'h0);

        // R4 clearing run drops active even with seq_active high
        ctrl_wr(16'h8000, 16'h0000);
        rd_chk("R4", CHAN, 0, exp_flags(0, 1, 1, 8'hA5));
        chk("R4", run_o, 0);

        // R5 accepted once inactive
        wr(CHAN, 3, 32'h1234_5678);
        wr(CHAN, 2, 32'h0000_00C0);
        m_word[2] = 32'h0000_00C0; m_word[3] = 32'h1234_5678;
        rd_chk("R5", CHAN, 3, 32'h1234_5678);
        chk("R5", cmd_ptr, 64'h0000_00C0_1234_5678);

        seq_active = 0; seq_dead = 0; seq_branch = 0; seq_status = 0;

        // R3 wake and flush pulses
        ctrl_wr(16'h1000, 16'h1000);
        chk("R3", {wake_pulse, flush_pulse}, 2'b10);
        rd_chk("R3", CHAN, 0, exp_flags(0, 0, 0, 0));
        @(negedge clk);
        chk("R3", wake_pulse, 0);
        ctrl_wr(16'h2000, 16'h2000);
        chk("R3", {wake_pulse, flush_pulse}, 2'b01);
        ctrl_wr(16'h2000, 16'h0000);
        chk("R3", flush_pulse, 0);

        // R1 random masked writes
        for (int k = 0; k < 60; k++) begin
            logic [15:0] m, v;
            m = 16'($urandom) & 16'hF000;
            v = 16'($urandom) & 16'hF000;
            ctrl_wr(m, v);
            chk("R3", {flush_pulse, wake_pulse}, {m[13] & v[13], m[12] & v[12]});
            chk("R1", {run_o, pause_o}, {m_run, m_pause});
            rd_chk("R1", CHAN, 0, exp_flags(0, 0, 0, 0));
        end
        ctrl_wr(16'hC000, 16'h0000);

        // R6 random word round trips
        for (int k = 0; k < 40; k++) begin
            int off;
            logic [31:0] v;
            off = 2 + int'($urandom % 11);
            v = $urandom;
            wr(CHAN, off, v);
            if (stored(off)) m_word[off] = v;
            rd_chk("R6", CHAN, off, stored(off) ? v : 32'h0);
        end
        chk("R6", cmd_ptr, {m_word[2], m_word[3]});
        chk("R6", data_ptr, {m_word[8], m_word[9]});
        chk("R6", branch_ptr, {m_word[11], m_word[12]});
        chk("R6", {int_sel, br_sel}, {m_word[4], m_word[5]});
        chk("R6", {wait_sel, xfer_mode}, {m_word[6], m_word[7]});
        // bus byte order directed
        wr(CHAN, 4, 32'h0102_0304);
        m_word[4] = 32'h0102_0304;
        addr = a_of(CHAN, 4); #1;
        chk("R6", rd_data, 32'h0403_0201);
        chk("R6", int_sel, 32'h0102_0304);

        // R8 reserved and out-of-range words
        wr(CHAN, 10, 32'hFFFF_FFFF);
        rd_chk("R8", CHAN, 10, 32'h0);
        for (int o = 13; o < 64; o += 17) begin
            wr(CHAN, o, 32'hA5A5_5A5A);
            rd_chk("R8", CHAN, o, 32'h0);
        end
        chk("R8", branch_ptr, {m_word[11], m_word[12]});

        // R9 other channel window
        wr(CHAN + 1, 4, 32'h7777_7777);
        wr(CHAN - 1, 0, 32'h8000_8000);
        rd_chk("R9", CHAN, 4, m_word[4]);
        rd_chk("R9", CHAN + 1, 4, 32'h0);
        chk("R9", run_o, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule